// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block drives the control lines of an analog PLL through a timed power-up order. A start pulse launches one of two orders. The general-purpose order puts the PLL into its standby operating mode. It then releases the active-low reset, and after a further gap it enables the output branch. The CPU-type order sets the bypass control, waits, and releases reset. In both orders the block then watches the lock indicator for a bounded window.

A lock seen inside the window ends the sequence with `done_o`. In the CPU-type order, lock also turns on the output control. If no lock arrives in time, the block raises `error_o`, keeps the output control off and returns to idle.

All gaps count whole microseconds. The microsecond tick comes from a clock-frequency parameter given in MHz. An optional state-machine-enable control can be requested with the start pulse.

Top module: `pll_bringup_seq`

## Requirements
- R1: While reset is asserted, and after its release before any start, every control output and `busy_o`, `done_o` and `error_o` are 0.
- R2: In the general-purpose order (`cpu_variant_i`=0 at start), `standby_o` rises first. `reset_n_o` rises no earlier than STBY_GAP_US*CLK_FREQ_MHZ cycles after it and no later than 2 cycles beyond that.
- R3: In the general-purpose order, `branch_en_o` rises between BRANCH_GAP_US*CLK_FREQ_MHZ and that value plus 2 cycles after `reset_n_o`, while both `reset_n_o` and `standby_o` stay high.
- R4: If `lock_i` rises and stays high within LOCK_WAIT_US microseconds after the last enable step (`branch_en_o` or `reset_n_o` for the CPU-type order), the sequence ends with `done_o`=1, `error_o`=0 and `busy_o`=0.
- R5: If `lock_i` stays low for the whole LOCK_WAIT_US window, the sequence ends with `error_o`=1, `done_o`=0, `busy_o`=0 and `out_en_o`=0.
- R6: In the CPU-type order (`cpu_variant_i`=1 at start), `bypass_o` rises first. `reset_n_o` rises between BYPASS_GAP_US*CLK_FREQ_MHZ and that value plus 2 cycles later. `standby_o` and `branch_en_o` stay 0.
- R7: `out_en_o` rises only in the CPU-type order, only after `lock_i` is high, and at most 4 cycles after it. It never rises in the general-purpose order.
- R8: `fsm_en_o` takes the value of `fsm_en_req_i` sampled with the start pulse and is in place no later than the first sequence control.
- R9: A start pulse while `busy_o`=1 is ignored: the running order, its variant and its timing continue unchanged.
- R10: `done_o` and `error_o` hold their value while idle and are both cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| cpu_variant_i | input | 1 | 1 selects the CPU-type order, 0 the general-purpose order |
| fsm_en_req_i | input | 1 | Requests the state-machine-enable control |
| lock_i | input | 1 | Lock indicator from the PLL (synchronised inside) |
| fsm_en_o | output | 1 | State-machine-enable control |
| standby_o | output | 1 | Standby operating-mode request |
| reset_n_o | output | 1 | Reset release (1 = out of reset) |
| branch_en_o | output | 1 | Output branch enable (general-purpose order) |
| bypass_o | output | 1 | Bypass control (CPU-type order) |
| out_en_o | output | 1 | Output control (CPU-type order, after lock) |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last sequence ended with lock |
| error_o | output | 1 | Last sequence timed out waiting for lock |

## Verification
The bench builds the block with CLK_FREQ_MHZ=4 and keeps the default gap lengths of 1, 10, 5 and 100 microseconds. Every microsecond is then only four cycles, so the 100 µs lock window is 400 cycles. A single run reaches both sides of the lock deadline: a lock 390 cycles after enable succeeds and one at 450 cycles times out. The model PLL in the bench raises lock a chosen number of cycles after the last enable step, or never. This makes the success, timeout and boundary outcomes of both orders reachable within a few thousand cycles.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GP_STBY,
    ST_GP_RST,
    ST_CPU_BYP,
    ST_LOCK
  } seq_state_e;

  typedef struct packed {
    logic fsm_en;
    logic standby;
    logic reset_n;
    logic branch_en;
    logic bypass;
    logic out_en;
  } pll_ctrl_t;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
  parameter int CLK_FREQ_MHZ = 100,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  localparam int PRE_W = (CLK_FREQ_MHZ > 1) ? $clog2(CLK_FREQ_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_FREQ_MHZ - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             us_tick;
  logic             run;

  assign us_tick = (pre_q == PRE_LAST);
  assign run     = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= load_val_i;
    end else if (run) begin
      pre_q <= us_tick ? '0 : pre_q + 1'b1;
      if (us_tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = !run;
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int STBY_GAP_US   = 1,
  parameter int BRANCH_GAP_US = 10,
  parameter int BYPASS_GAP_US = 5,
  parameter int LOCK_WAIT_US  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cpu_i,
  input  logic             fsm_req_i,
  input  logic             lock_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output pll_ctrl_t        ctrl_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  seq_state_e state_q, state_d;
  pll_ctrl_t  ctrl_q, ctrl_d;
  logic       cpu_q, cpu_d;
  logic       done_q, done_d;
  logic       err_q, err_d;

  always_comb begin
    state_d    = state_q;
    ctrl_d     = ctrl_q;
    cpu_d      = cpu_q;
    done_d     = done_q;
    err_d      = err_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctrl_d        = '0;
          ctrl_d.fsm_en = fsm_req_i;
          cpu_d         = cpu_i;
          done_d        = 1'b0;
          err_d         = 1'b0;
          load_o        = 1'b1;
          if (cpu_i) begin
            ctrl_d.bypass = 1'b1;
            load_val_o    = CNT_W'(BYPASS_GAP_US);
            state_d       = ST_CPU_BYP;
          end else begin
            ctrl_d.standby = 1'b1;
            load_val_o     = CNT_W'(STBY_GAP_US);
            state_d        = ST_GP_STBY;
          end
        end
      end
      ST_GP_STBY: begin
        if (expired_i) begin
          ctrl_d.reset_n = 1'b1;
          load_o         = 1'b1;
          load_val_o     = CNT_W'(BRANCH_GAP_US);
          state_d        = ST_GP_RST;
        end
      end
      ST_GP_RST: begin
        if (expired_i) begin
          ctrl_d.branch_en = 1'b1;
          load_o           = 1'b1;
          load_val_o       = CNT_W'(LOCK_WAIT_US);
          state_d          = ST_LOCK;
        end
      end
      ST_CPU_BYP: begin
        if (expired_i) begin
          ctrl_d.reset_n = 1'b1;
          load_o         = 1'b1;
          load_val_o     = CNT_W'(LOCK_WAIT_US);
          state_d        = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (lock_i) begin
          done_d        = 1'b1;
          ctrl_d.out_en = cpu_q;
          state_d       = ST_IDLE;
        end else if (expired_i) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      cpu_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      cpu_q   <= cpu_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_FREQ_MHZ  = 200,
  parameter int STBY_GAP_US   = 1,
  parameter int BRANCH_GAP_US = 10,
  parameter int BYPASS_GAP_US = 5,
  parameter int LOCK_WAIT_US  = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cpu_variant_i,
  input  logic fsm_en_req_i,
  input  logic lock_i,
  output logic fsm_en_o,
  output logic standby_o,
  output logic reset_n_o,
  output logic branch_en_o,
  output logic bypass_o,
  output logic out_en_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);
  localparam int GAP_MAX_A = (STBY_GAP_US > BRANCH_GAP_US) ? STBY_GAP_US : BRANCH_GAP_US;
  localparam int GAP_MAX_B = (BYPASS_GAP_US > LOCK_WAIT_US) ? BYPASS_GAP_US : LOCK_WAIT_US;
  localparam int GAP_MAX   = (GAP_MAX_A > GAP_MAX_B) ? GAP_MAX_A : GAP_MAX_B;
  localparam int CNT_W     = $clog2(GAP_MAX + 1);

  logic             lock_s;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  pll_ctrl_t        ctrl;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lock_i), .sync_o(lock_s)
  );

  pll_us_timer #(.CLK_FREQ_MHZ(CLK_FREQ_MHZ), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_expired)
  );

  pll_seq_fsm #(
    .CNT_W(CNT_W), .STBY_GAP_US(STBY_GAP_US), .BRANCH_GAP_US(BRANCH_GAP_US),
    .BYPASS_GAP_US(BYPASS_GAP_US), .LOCK_WAIT_US(LOCK_WAIT_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpu_i(cpu_variant_i),
    .fsm_req_i(fsm_en_req_i), .lock_i(lock_s), .expired_i(tmr_expired),
    .load_o(tmr_load), .load_val_o(tmr_val), .ctrl_o(ctrl),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  assign fsm_en_o    = ctrl.fsm_en;
  assign standby_o   = ctrl.standby;
  assign reset_n_o   = ctrl.reset_n;
  assign branch_en_o = ctrl.branch_en;
  assign bypass_o    = ctrl.bypass;
  assign out_en_o    = ctrl.out_en;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int CLK_FREQ_MHZ = 200,
  parameter int STBY_GAP_US  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic lock_i,
  input logic standby_o,
  input logic reset_n_o,
  input logic branch_en_o,
  input logic bypass_o,
  input logic out_en_o,
  input logic busy_o,
  input logic done_o,
  input logic error_o
);
  int unsigned stby_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stby_cnt <= 0;
    else if (!standby_o)     stby_cnt <= 0;
    else if (stby_cnt < 32'hFFFF_FFFF) stby_cnt <= stby_cnt + 1;
  end

  // R2
  stby_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) && standby_o |-> stby_cnt >= STBY_GAP_US * CLK_FREQ_MHZ);

  // R3
  branch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(branch_en_o) |-> reset_n_o && standby_o);

  // R4
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  // R5
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> !out_en_o && !busy_o);

  // R9
  bypass_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_o) |-> !$past(busy_o));

  // R7
  out_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> $past(lock_i) && bypass_o && reset_n_o);
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
  .CLK_FREQ_MHZ(CLK_FREQ_MHZ), .STBY_GAP_US(STBY_GAP_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .standby_o(standby_o),
  .reset_n_o(reset_n_o), .branch_en_o(branch_en_o), .bypass_o(bypass_o),
  .out_en_o(out_en_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/test_pll_bringup_seq.sv
`timescale 1ns/1ps
module test_pll_bringup_seq;
  localparam int F      = 4;
  localparam int G_STBY = 1 * F;
  localparam int G_BR   = 10 * F;
  localparam int G_BYP  = 5 * F;

  typedef struct packed {
    logic     cpu;
    logic     fsm;
    int       lockdly;
    logic     exp_done;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b0, 50,  1'b1},
    '{1'b0, 1'b1, 390, 1'b1},
    '{1'b0, 1'b0, 0,   1'b0},
    '{1'b1, 1'b0, 20,  1'b1},
    '{1'b1, 1'b1, 0,   1'b0},
    '{1'b1, 1'b0, 450, 1'b0},
    '{1'b0, 1'b1, 1,   1'b1}
  };

  logic clk, rst_n, start_i, cpu_variant_i, fsm_en_req_i, lock_i;
  logic fsm_en_o, standby_o, reset_n_o, branch_en_o, bypass_o, out_en_o;
  logic busy_o, done_o, error_o;

  int total, bad, cyc;
  int t_stby, t_rst, t_br, t_byp, t_out, t_lock, t_end;
  logic fsm_late, s1_done, s1_err, fsm_seen;

  pll_bringup_seq #(.CLK_FREQ_MHZ(F)) i_pll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpu_variant_i(cpu_variant_i),
    .fsm_en_req_i(fsm_en_req_i), .lock_i(lock_i), .fsm_en_o(fsm_en_o),
    .standby_o(standby_o), .reset_n_o(reset_n_o), .branch_en_o(branch_en_o),
    .bypass_o(bypass_o), .out_en_o(out_en_o), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic cpu, input logic fsm, input int lockdly,
                         input bit poke);
    int en_t;
    t_stby = -1; t_rst = -1; t_br = -1; t_byp = -1; t_out = -1;
    t_lock = -1; t_end = -1; fsm_late = 1'b0; fsm_seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1; cpu_variant_i = cpu; fsm_en_req_i = fsm; lock_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    s1_done = done_o; s1_err = error_o;
    for (int t = 1; t < 3000; t++) begin
      if (standby_o   && t_stby < 0) t_stby = t;
      if (reset_n_o   && t_rst  < 0) t_rst  = t;
      if (branch_en_o && t_br   < 0) t_br   = t;
      if (bypass_o    && t_byp  < 0) t_byp  = t;
      if (out_en_o    && t_out  < 0) t_out  = t;
      if (fsm_en_o) fsm_seen = 1'b1;
      if (fsm && !fsm_en_o && (standby_o || bypass_o)) fsm_late = 1'b1;
      if (done_o || error_o) begin t_end = t; break; end
      en_t = cpu ? t_rst : t_br;
      if (lockdly > 0 && en_t >= 0 && (t - en_t) >= lockdly) lock_i = 1'b1;
      if (lock_i && t_lock < 0) t_lock = t;
      if (poke && t == 10) begin
        start_i = 1'b1; cpu_variant_i = ~cpu; fsm_en_req_i = ~fsm;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; start_i = 1'b0; cpu_variant_i = 1'b0;
    fsm_en_req_i = 1'b0; lock_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({fsm_en_o, standby_o, reset_n_o, branch_en_o, bypass_o, out_en_o,
         busy_o, done_o, error_o} == 9'b0, "R1", "outputs in reset",
        int'({fsm_en_o, standby_o, reset_n_o, branch_en_o, bypass_o, out_en_o,
              busy_o, done_o, error_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy_o, done_o, error_o, standby_o, bypass_o} == 5'b0, "R1",
        "outputs after release", int'({busy_o, done_o, error_o}), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t x;
      x = VECS[v];
      run_seq(x.cpu, x.fsm, x.lockdly, 1'b0);
      chk(done_o == x.exp_done, x.exp_done ? "R4" : "R5", "done_o", done_o, x.exp_done);
      chk(error_o == !x.exp_done, x.exp_done ? "R4" : "R5", "error_o", error_o, !x.exp_done);
      chk(busy_o == 1'b0, "R4", "busy_o at end", busy_o, 0);
      chk(s1_done == 1'b0 && s1_err == 1'b0, "R10", "status cleared by start",
          int'({s1_done, s1_err}), 0);
      chk(fsm_seen == x.fsm && !fsm_late, "R8", "fsm_en_o", fsm_seen, x.fsm);
      chk(out_en_o == (x.cpu && x.exp_done), "R7", "out_en_o",
          out_en_o, int'(x.cpu && x.exp_done));
      if (!x.exp_done)
        chk(t_out < 0, "R5", "out_en_o rose on timeout", t_out, -1);
      if (x.cpu) begin
        chk(t_byp == 1 && t_stby < 0 && t_br < 0, "R6", "bypass first", t_byp, 1);
        chk(t_rst - t_byp >= G_BYP && t_rst - t_byp <= G_BYP + 2, "R6",
            "bypass->reset gap", t_rst - t_byp, G_BYP);
        if (x.exp_done)
          chk(t_lock >= 0 && t_out > t_lock && t_out <= t_lock + 4, "R7",
              "out_en after lock", t_out - t_lock, 3);
      end else begin
        chk(t_stby == 1 && t_byp < 0, "R2", "standby first", t_stby, 1);
        chk(t_rst - t_stby >= G_STBY && t_rst - t_stby <= G_STBY + 2, "R2",
            "standby->reset gap", t_rst - t_stby, G_STBY);
        chk(t_br - t_rst >= G_BR && t_br - t_rst <= G_BR + 2, "R3",
            "reset->branch gap", t_br - t_rst, G_BR);
        chk(t_out < 0, "R7", "out_en in general order", t_out, -1);
      end
      repeat (5) @(negedge clk);
      chk(done_o == x.exp_done && error_o == !x.exp_done, "R10",
          "status held while idle", int'({done_o, error_o}),
          int'({x.exp_done, !x.exp_done}));
    end

    // R9: start with the other variant while busy
    run_seq(1'b0, 1'b0, 30, 1'b1);
    chk(t_byp < 0, "R9", "bypass_o from ignored start", t_byp, -1);
    chk(fsm_seen == 1'b0, "R9", "fsm_en_o from ignored start", fsm_seen, 0);
    chk(t_br - t_rst >= G_BR && t_br - t_rst <= G_BR + 2, "R9",
        "timing kept after ignored start", t_br - t_rst, G_BR);
    chk(done_o == 1'b1, "R9", "sequence completes", done_o, 1);

    // R1: reset in the middle of a CPU-type run
    @(negedge clk);
    start_i = 1'b1; cpu_variant_i = 1'b1; fsm_en_req_i = 1'b1; lock_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({fsm_en_o, reset_n_o, bypass_o, busy_o, done_o} == 5'b0, "R1",
        "outputs after mid-run reset",
        int'({fsm_en_o, reset_n_o, bypass_o, busy_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule